// File: doc/BRIEF.md
# Delegated Counter Indirect Access Unit

This block sits beside the supervisor indirect register path and decides what happens to an access whose selector falls inside the counter window. Each counter occupies one selector slot above a fixed base. The block receives:

- the selector value and which of six alias registers is touched;
- the current privilege and virtualization state, and the register width;
- a machine-level delegation enable and the machine counter-enable mask;
- flags saying which optional counter features exist.

It returns, in the same cycle, either a grant (counter index plus a sub-register code) or an exception code, illegal or virtual.

Reads pass through a mask that forces the machine-mode inhibit filter bit of a configuration word to zero. Granted writes leave the block one cycle later as a single-cycle strobe, carrying index, sub-register code and masked data. Counter storage and state-enable gating live elsewhere. The gating decision enters as a block flag plus the fault code to report.

All pins are plain control and data. The write strobe is a one-cycle pulse with no back-pressure, since the counter file always accepts a write.

Top module: `dcia_top`

## Requirements
- R1: A selector from 0x040 to 0x05F raises `hit` and names counter index selector minus 0x040. Outside that range, `fault` stays 00 and `grant` stays 0.
- R2: Alias register 1 maps to sub code 0 (low word), 4 to code 1 (high word), 2 to code 2 (config/event), and 5 to code 3 (config high).
- R3: In M or S mode (priv 11 or 01, virt 0) with `deleg_en` 0, an access in the window returns illegal (fault 01).
- R4: Alias numbers other than 1, 2, 4 and 5, notably 3 and 6, return illegal.
- R5: With `xlen64` set, alias 4 or 5 returns illegal.
- R6: Index 1 (timer slot) returns illegal, and so does any index whose `cnt_en` bit is 0.
- R7: Feature presence is required. Indices 0 and 2 need `feat[3]`. Indices 3..31 need `feat[2]`. Sub codes 2 and 3 of indices 0/2 also need `feat[0]`. Sub code 3 of indices 3..31 also needs `feat[1]`. A missing feature returns illegal.
- R8: Virtualized and user-level accesses are decided as follows:
  - With virt 1, an access to the virtual alias set (`vsel`) or from VU returns virtual (10).
  - A VS access to the normal alias set returns illegal if `deleg_en` is 0 and virtual if it is 1.
  - With virt 0, U mode or `vsel` returns illegal.
- R9: `rd_data` equals `rd_raw` except that bit 62 (sub code 2, `xlen64`=1) or bit 30 (sub code 3) reads as 0.
- R10: Bit 62 or bit 30, chosen the same way as in R9, is cleared in `wr_data`, so a write to it has no effect.
- R11: With `gate_block` set and a hit, `fault` equals `gate_fault` and no grant is given.
- R12: The checks apply in this order: gating, mode, delegation, alias number, width, index and mask, features. A grant is given only when every check passes, and then `fault` is 00.
- R13: A granted write raises `wr_stb` for exactly one cycle on the next clock, carrying index, sub code and masked data. Reads and faulting writes raise no strobe.
- R14: After reset, `wr_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| acc_valid | input | 1 | an access is presented this cycle |
| acc_write | input | 1 | access is a write |
| priv | input | 2 | privilege: 00 U, 01 S, 11 M |
| virt | input | 1 | virtualization mode active |
| vsel | input | 1 | access names the virtual alias set directly |
| xlen64 | input | 1 | register width is 64 |
| sel | input | SEL_W | effective selector value |
| alias_n | input | 3 | alias register number 1..6 |
| deleg_en | input | 1 | machine-level delegation enable |
| cnt_en | input | NCNT | machine counter-enable mask |
| feat | input | 4 | {base counters, programmable counters, event filter, cycle/instret config} |
| gate_block | input | 1 | state-enable gating blocks the access |
| gate_fault | input | 2 | fault code produced by the gating logic |
| wdata | input | DW | write data |
| rd_raw | input | DW | raw read data from counter storage |
| hit | output | 1 | selector inside the counter window |
| fault | output | 2 | 00 none, 01 illegal, 10 virtual |
| grant | output | 1 | access allowed |
| cnt_idx | output | IDX_W | selected counter index |
| sub_code | output | 2 | selected sub-register |
| rd_data | output | DW | masked read data |
| wr_stb | output | 1 | one-cycle write strobe |
| wr_idx | output | IDX_W | counter index of the write |
| wr_sub | output | 2 | sub-register of the write |
| wr_data | output | DW | masked write data |

## Verification
The hardest situations to reach are accesses that break several rules at once. In those, only the priority order decides which code appears. A VS access to alias 3 at the timer slot with every feature missing must still report virtual. The vector table places such collisions next to single-fault rows, so each check level is seen both alone and masked by an earlier one. The bit-30 case, the high config half in 32-bit mode, is driven directly on both the read and the write path.

// File: rtl/dcia_pkg.sv
package dcia_pkg;
  typedef enum logic [1:0] {FLT_NONE = 2'b00, FLT_ILL = 2'b01, FLT_VIRT = 2'b10} fault_e;
  typedef enum logic [1:0] {SUB_LO = 2'd0, SUB_HI = 2'd1, SUB_CFG = 2'd2, SUB_CFGH = 2'd3} sub_e;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;
endpackage

// File: rtl/dcia_window.sv
module dcia_window #(
  parameter int SEL_W = 12,
  parameter int NCNT = 32,
  parameter logic [SEL_W-1:0] BASE = 12'h040,
  localparam int IDX_W = $clog2(NCNT)
) (
  input  logic [SEL_W-1:0] sel,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic [SEL_W-1:0] off;
  always_comb begin
    off = sel - BASE;
    hit = (sel >= BASE) && (off < SEL_W'(NCNT));
    idx = off[IDX_W-1:0];
  end
endmodule

// File: rtl/dcia_check.sv
module dcia_check
  import dcia_pkg::*;
#(
  parameter int NCNT = 32,
  parameter int TIME_IDX = 1,
  localparam int IDX_W = $clog2(NCNT)
) (
  input  logic             valid,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       priv,
  input  logic             virt,
  input  logic             vsel,
  input  logic             xlen64,
  input  logic [2:0]       alias_n,
  input  logic             deleg_en,
  input  logic [NCNT-1:0]  cnt_en,
  input  logic [3:0]       feat,
  input  logic             gate_block,
  input  logic [1:0]       gate_fault,
  output fault_e           fault,
  output logic             grant,
  output sub_e             sub
);
  logic alias_ok, hi_alias, base_ctr, feat_ok;

  always_comb begin
    alias_ok = 1'b1;
    hi_alias = 1'b0;
    sub = SUB_LO;
    case (alias_n)
      3'd1: sub = SUB_LO;
      3'd4: begin sub = SUB_HI; hi_alias = 1'b1; end
      3'd2: sub = SUB_CFG;
      3'd5: begin sub = SUB_CFGH; hi_alias = 1'b1; end
      default: alias_ok = 1'b0;
    endcase
  end

  always_comb begin
    base_ctr = (idx == IDX_W'(0)) || (idx == IDX_W'(2));
    if (base_ctr)
      feat_ok = feat[3] && (!sub[1] || feat[0]);
    else
      feat_ok = feat[2] && (sub != SUB_CFGH || feat[1]);
  end

  always_comb begin
    fault = FLT_NONE;
    grant = 1'b0;
    if (valid && hit) begin
      if (gate_block)                                  fault = fault_e'(gate_fault);
      else if (virt)                                   fault = (priv == PRIV_U || vsel || deleg_en) ? FLT_VIRT : FLT_ILL;
      else if (priv == PRIV_U || vsel)                 fault = FLT_ILL;
      else if (!deleg_en)                              fault = FLT_ILL;
      else if (!alias_ok)                              fault = FLT_ILL;
      else if (xlen64 && hi_alias)                     fault = FLT_ILL;
      else if (idx == IDX_W'(TIME_IDX) || !cnt_en[idx]) fault = FLT_ILL;
      else if (!feat_ok)                               fault = FLT_ILL;
      else                                             grant = 1'b1;
    end
  end
endmodule

// File: rtl/dcia_bitmask.sv
module dcia_bitmask
  import dcia_pkg::*;
#(
  parameter int DW = 64,
  parameter int FILT_BIT = 62,
  localparam int FILT_HI = FILT_BIT - 32
) (
  input  sub_e          sub,
  input  logic          xlen64,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_comb begin
    dout = din;
    if (sub == SUB_CFG && xlen64) dout[FILT_BIT] = 1'b0;
    if (sub == SUB_CFGH)          dout[FILT_HI]  = 1'b0;
  end
endmodule

// File: rtl/dcia_wstage.sv
module dcia_wstage
  import dcia_pkg::*;
#(
  parameter int NCNT = 32,
  parameter int DW = 64,
  localparam int IDX_W = $clog2(NCNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [IDX_W-1:0] idx,
  input  sub_e             sub,
  input  logic [DW-1:0]    data,
  output logic             stb,
  output logic [IDX_W-1:0] s_idx,
  output logic [1:0]       s_sub,
  output logic [DW-1:0]    s_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb <= 1'b0;
      s_idx <= '0;
      s_sub <= '0;
      s_data <= '0;
    end else begin
      stb <= req;
      if (req) begin
        s_idx <= idx;
        s_sub <= sub;
        s_data <= data;
      end
    end
  end

  assert_stb_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> $past(req));
  assert_stb_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !req) |=> !stb);
endmodule

// File: rtl/dcia_top.sv
module dcia_top
  import dcia_pkg::*;
#(
  parameter int SEL_W = 12,
  parameter int NCNT = 32,
  parameter int DW = 64,
  parameter int FILT_BIT = 62,
  localparam int IDX_W = $clog2(NCNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [1:0]       priv,
  input  logic             virt,
  input  logic             vsel,
  input  logic             xlen64,
  input  logic [SEL_W-1:0] sel,
  input  logic [2:0]       alias_n,
  input  logic             deleg_en,
  input  logic [NCNT-1:0]  cnt_en,
  input  logic [3:0]       feat,
  input  logic             gate_block,
  input  logic [1:0]       gate_fault,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    rd_raw,
  output logic             hit,
  output logic [1:0]       fault,
  output logic             grant,
  output logic [IDX_W-1:0] cnt_idx,
  output logic [1:0]       sub_code,
  output logic [DW-1:0]    rd_data,
  output logic             wr_stb,
  output logic [IDX_W-1:0] wr_idx,
  output logic [1:0]       wr_sub,
  output logic [DW-1:0]    wr_data
);
  fault_e flt;
  sub_e   sub;
  logic [DW-1:0] wmasked;

  dcia_window #(.SEL_W(SEL_W), .NCNT(NCNT)) u_win (.sel(sel), .hit(hit), .idx(cnt_idx));

  dcia_check #(.NCNT(NCNT)) u_chk (
    .valid(acc_valid), .hit(hit), .idx(cnt_idx), .priv(priv), .virt(virt), .vsel(vsel),
    .xlen64(xlen64), .alias_n(alias_n), .deleg_en(deleg_en), .cnt_en(cnt_en), .feat(feat),
    .gate_block(gate_block), .gate_fault(gate_fault), .fault(flt), .grant(grant), .sub(sub));

  dcia_bitmask #(.DW(DW), .FILT_BIT(FILT_BIT)) u_rmask (.sub(sub), .xlen64(xlen64), .din(rd_raw), .dout(rd_data));
  dcia_bitmask #(.DW(DW), .FILT_BIT(FILT_BIT)) u_wmask (.sub(sub), .xlen64(xlen64), .din(wdata), .dout(wmasked));

  dcia_wstage #(.NCNT(NCNT), .DW(DW)) u_ws (
    .clk(clk), .rst_n(rst_n), .req(grant && acc_write), .idx(cnt_idx), .sub(sub), .data(wmasked),
    .stb(wr_stb), .s_idx(wr_idx), .s_sub(wr_sub), .s_data(wr_data));

  assign fault = flt;
  assign sub_code = sub;

  assert_grant_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (fault == 2'b00) && hit && acc_valid);
  assert_grant_deleg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> deleg_en && !virt);
  assert_grant_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> cnt_en[cnt_idx] && (cnt_idx != IDX_W'(1)));
  assert_gate_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hit && gate_block) |-> (fault == gate_fault) && !grant);
  assert_outside_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (fault == 2'b00) && !grant);
  assert_wr_filt_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_sub == 2'd3) |-> !wr_data[FILT_BIT-32]);
endmodule

// File: tb/sim_dcia_top.sv
module sim_dcia_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic acc_valid, acc_write, virt, vsel, xlen64, deleg_en, gate_block;
  logic [1:0] priv, gate_fault;
  logic [11:0] sel;
  logic [2:0] alias_n;
  logic [31:0] cnt_en;
  logic [3:0] feat;
  logic [63:0] wdata, rd_raw;
  logic hit, grant, wr_stb;
  logic [1:0] fault, sub_code, wr_sub;
  logic [4:0] cnt_idx, wr_idx;
  logic [63:0] rd_data, wr_data;

  dcia_top u0 (.*);

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0] pv; logic vt; logic vs; logic x64; logic dg; logic [2:0] al;
    logic [11:0] sl; logic [3:0] ft; logic [1:0] ef; logic eg; logic [1:0] es; logic [3:0] rq;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{2'b11,1'b0,1'b0,1'b1,1'b1,3'd1,12'h040,4'hF,2'b00,1'b1,2'd0,4'd2},  // R2 low
    '{2'b01,1'b0,1'b0,1'b0,1'b1,3'd4,12'h042,4'hF,2'b00,1'b1,2'd1,4'd2},  // R2 high
    '{2'b01,1'b0,1'b0,1'b0,1'b1,3'd2,12'h045,4'hF,2'b00,1'b1,2'd2,4'd2},  // R2 cfg
    '{2'b01,1'b0,1'b0,1'b0,1'b1,3'd5,12'h05F,4'hF,2'b00,1'b1,2'd3,4'd1},  // R1 top slot
    '{2'b11,1'b0,1'b0,1'b1,1'b0,3'd1,12'h040,4'hF,2'b01,1'b0,2'd0,4'd3},  // R3
    '{2'b01,1'b0,1'b0,1'b1,1'b1,3'd3,12'h040,4'hF,2'b01,1'b0,2'd0,4'd4},  // R4
    '{2'b01,1'b0,1'b0,1'b1,1'b1,3'd6,12'h040,4'hF,2'b01,1'b0,2'd0,4'd4},  // R4
    '{2'b01,1'b0,1'b0,1'b1,1'b1,3'd4,12'h040,4'hF,2'b01,1'b0,2'd0,4'd5},  // R5
    '{2'b01,1'b0,1'b0,1'b1,1'b1,3'd5,12'h044,4'hF,2'b01,1'b0,2'd0,4'd5},  // R5
    '{2'b01,1'b0,1'b0,1'b0,1'b1,3'd1,12'h041,4'hF,2'b01,1'b0,2'd0,4'd6},  // R6 timer
    '{2'b01,1'b0,1'b0,1'b0,1'b1,3'd1,12'h043,4'hF,2'b01,1'b0,2'd0,4'd6},  // R6 mask
    '{2'b01,1'b0,1'b0,1'b0,1'b1,3'd1,12'h040,4'h7,2'b01,1'b0,2'd0,4'd7},  // R7 base
    '{2'b01,1'b0,1'b0,1'b0,1'b1,3'd2,12'h040,4'hE,2'b01,1'b0,2'd0,4'd7},  // R7 cfg
    '{2'b01,1'b0,1'b0,1'b0,1'b1,3'd2,12'h044,4'hD,2'b00,1'b1,2'd2,4'd7},  // R7 event lo
    '{2'b01,1'b0,1'b0,1'b0,1'b1,3'd5,12'h044,4'hD,2'b01,1'b0,2'd0,4'd7},  // R7 event hi
    '{2'b01,1'b0,1'b0,1'b0,1'b1,3'd1,12'h044,4'hB,2'b01,1'b0,2'd0,4'd7},  // R7 hpm
    '{2'b01,1'b1,1'b0,1'b1,1'b0,3'd1,12'h040,4'hF,2'b01,1'b0,2'd0,4'd8},  // R8 VS deleg0
    '{2'b01,1'b1,1'b0,1'b1,1'b1,3'd1,12'h040,4'hF,2'b10,1'b0,2'd0,4'd8},  // R8 VS deleg1
    '{2'b11,1'b0,1'b1,1'b1,1'b1,3'd1,12'h040,4'hF,2'b01,1'b0,2'd0,4'd8},  // R8 M vsel
    '{2'b01,1'b1,1'b1,1'b1,1'b1,3'd1,12'h040,4'hF,2'b10,1'b0,2'd0,4'd8},  // R8 VS vsel
    '{2'b00,1'b1,1'b0,1'b1,1'b1,3'd1,12'h040,4'hF,2'b10,1'b0,2'd0,4'd8},  // R8 VU
    '{2'b00,1'b0,1'b0,1'b1,1'b1,3'd1,12'h040,4'hF,2'b01,1'b0,2'd0,4'd8},  // R8 U
    '{2'b01,1'b1,1'b0,1'b1,1'b1,3'd3,12'h041,4'h0,2'b10,1'b0,2'd0,4'd12}, // R12 mode wins
    '{2'b01,1'b0,1'b0,1'b1,1'b1,3'd1,12'h03F,4'hF,2'b00,1'b0,2'd0,4'd1},  // R1 below
    '{2'b01,1'b0,1'b0,1'b1,1'b1,3'd1,12'h060,4'hF,2'b00,1'b0,2'd0,4'd1}   // R1 above
  };

  task automatic set_acc(input logic [1:0] pv, input logic vt, input logic vs, input logic x64,
                         input logic dg, input logic [2:0] al, input logic [11:0] sl, input logic [3:0] ft);
    priv = pv; virt = vt; vsel = vs; xlen64 = x64; deleg_en = dg; alias_n = al; sel = sl; feat = ft;
  endtask

  initial begin : watchdog
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    acc_valid = 1'b0; acc_write = 1'b0; gate_block = 1'b0; gate_fault = 2'b00;
    cnt_en = 32'hFFFF_FFF5; wdata = '0; rd_raw = '0;
    set_acc(2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 12'h040, 4'hF);
    repeat (3) @(negedge clk);
    chk("R14 stb in reset", {63'd0, wr_stb}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R14 stb after reset", {63'd0, wr_stb}, 64'd0);

    acc_valid = 1'b1;
    for (int k = 0; k < NV; k++) begin
      set_acc(VEC[k].pv, VEC[k].vt, VEC[k].vs, VEC[k].x64, VEC[k].dg, VEC[k].al, VEC[k].sl, VEC[k].ft);
      #2;
      chk($sformatf("R%0d vec%0d fault", VEC[k].rq, k), {62'd0, fault}, {62'd0, VEC[k].ef});
      chk($sformatf("R%0d vec%0d grant", VEC[k].rq, k), {63'd0, grant}, {63'd0, VEC[k].eg});
      if (VEC[k].eg) begin
        chk($sformatf("R%0d vec%0d sub", VEC[k].rq, k), {62'd0, sub_code}, {62'd0, VEC[k].es});
        chk($sformatf("R1 vec%0d idx", k), {59'd0, cnt_idx}, 64'(VEC[k].sl - 12'h040));
      end
      @(negedge clk);
    end

    // R11 gating passthrough on an otherwise grantable access
    set_acc(2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 12'h040, 4'hF);
    gate_block = 1'b1; gate_fault = 2'b10; #2;
    chk("R11 gate fault", {62'd0, fault}, 64'd2);
    chk("R11 gate no grant", {63'd0, grant}, 64'd0);
    gate_fault = 2'b00; #2;
    chk("R11 gate none", {62'd0, fault, grant}, 64'd0);
    gate_block = 1'b0;
    @(negedge clk);

    // R9 read masking
    rd_raw = '1;
    set_acc(2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 12'h044, 4'hF); #2;
    chk("R9 cfg64 read", rd_data, 64'hBFFF_FFFF_FFFF_FFFF);
    set_acc(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, 12'h044, 4'hF); #2;
    chk("R9 cfgh read", rd_data, 64'hFFFF_FFFF_BFFF_FFFF);
    set_acc(2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 12'h044, 4'hF); #2;
    chk("R9 low read", rd_data, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    chk("R13 read no stb", {63'd0, wr_stb}, 64'd0);

    // R10 / R13 write strobe
    wdata = '1; acc_write = 1'b1;
    set_acc(2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 12'h044, 4'hF);
    @(negedge clk);
    acc_write = 1'b0;
    chk("R13 stb", {63'd0, wr_stb}, 64'd1);
    chk("R13 idx", {59'd0, wr_idx}, 64'd4);
    chk("R13 sub", {62'd0, wr_sub}, 64'd2);
    chk("R10 data62", wr_data, 64'hBFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    chk("R13 one cycle", {63'd0, wr_stb}, 64'd0);
    acc_write = 1'b1;
    set_acc(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, 12'h045, 4'hF);
    @(negedge clk);
    acc_write = 1'b0;
    chk("R10 data30", wr_data, 64'hFFFF_FFFF_BFFF_FFFF);
    chk("R13 idx5", {59'd0, wr_idx}, 64'd5);
    acc_write = 1'b1;
    set_acc(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 12'h043, 4'hF);
    @(negedge clk);
    acc_write = 1'b0;
    chk("R13 fault no stb", {63'd0, wr_stb}, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule